// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a physical address by reading a two-level page table stored in memory. A request carries the virtual address and the kind of access (read, write or execute). The walker fetches one entry from the outer table, then one entry from the inner table that the outer entry points at. It answers with either the physical address or a fault and a cause code.

The walker talks to memory through a simple read port. It holds a request with a word address, and memory returns one 32-bit word, marked by a one-cycle valid pulse, after any delay of one cycle or more. The root of the table is a 20-bit frame number supplied by the page-table base input. That input is captured when a request is accepted. Each table fills exactly one 4 KB frame of 1024 four-byte entries. Only one walk is in flight at a time.

Top module: `ptw_top`

## Requirements
- R1: While reset is high and after it is released, `ready` is 1 and `mem_req` and `resp_valid` are 0 until a request is accepted.
- R2: A request is taken only when `req_valid` and `ready` are both 1 at a clock edge. A request presented while a walk is running is ignored and does not alter that walk's reads or its result.
- R3: The first read goes to `{ptbr, 12'h000} + vaddr[31:22]*4`. `mem_req` stays high with a stable, word-aligned `mem_addr` until `mem_rvalid` returns.
- R4: The second read goes to `{outer_entry[31:12], 12'h000} + vaddr[21:12]*4`.
- R5: An entry holds a frame number in bits 31:12 and flags in bits 11:0. Flag bit 0 means valid, bit 1 readable, bit 2 writable and bit 3 executable.
- R6: A successful walk returns `resp_fault`=0, `resp_cause`=0 and `resp_paddr = {inner_entry[31:12], vaddr[11:0]}`, with the offset passed through unchanged.
- R7: An outer entry with bit 0 clear ends the walk with `resp_fault`=1 and `resp_cause`=1, and no inner read is issued.
- R8: An inner entry with bit 0 clear gives `resp_cause`=2. This takes precedence over any permission check.
- R9: The access code is 0 for read, 1 for write, 2 for execute and 3 for reserved. If the inner entry lacks the matching permission bit, the walk gives `resp_cause`=3. Code 3 always gives `resp_cause`=3. Permission bits in the outer entry are not checked.
- R10: `resp_valid` rises exactly one cycle after the clock edge that takes the final read data and lasts one cycle. `ready` returns in the following cycle.
- R11: The translation result does not depend on memory latency, for any delay of one or more cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_access | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| ptbr | input | 20 | Frame number of the outer table |
| ready | output | 1 | Walker idle and able to take a request |
| mem_req | output | 1 | Read request, held until data returns |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_rvalid | input | 1 | Read data valid pulse |
| mem_rdata | input | 32 | Entry word returned by memory |
| resp_valid | output | 1 | One-cycle result strobe |
| resp_fault | output | 1 | Result is a fault |
| resp_cause | output | 2 | 0 none, 1 outer invalid, 2 inner invalid, 3 protection |
| resp_paddr | output | 32 | Physical address on success |

## Verification
A request is taken at the clock edge where `req_valid` and `ready` are both high. `mem_req` appears in the next cycle, and each read ends at the edge that samples `mem_rvalid`. The result is due in the cycle after the edge that takes the last read, and `ready` one cycle after that. The bench drives inputs on the falling edge and samples on the falling edge. It also notes the cycle count at which its memory model raised the final data pulse, and it requires the result to appear exactly one count later. Its memory model logs every address it is asked for. A behavioural walk over the same memory contents predicts that address list, the cause and the physical address under latencies of 1, 3 and 7 cycles.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    // Address geometry
    localparam int VA_W        = 32;
    localparam int OFF_W       = 12;
    localparam int IDX_W       = 10;
    localparam int PTE_W       = 32;
    localparam int FRAME_W     = VA_W - OFF_W;
    localparam int FLAG_W      = PTE_W - FRAME_W;
    localparam int ENTRY_BYTES = PTE_W / 8;
    localparam int ENTRY_SH    = $clog2(ENTRY_BYTES);

    // Flag bit positions inside an entry
    localparam int FLG_VALID = 0;
    localparam int FLG_READ  = 1;
    localparam int FLG_WRITE = 2;
    localparam int FLG_EXEC  = 3;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_OUTER = 3'd1,
        ST_RD_INNER = 3'd2,
        ST_DONE     = 3'd3,
        ST_FAULT    = 3'd4
    } walk_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE      = 2'd0,
        CAUSE_OUTER_INV = 2'd1,
        CAUSE_INNER_INV = 2'd2,
        CAUSE_PROT      = 2'd3
    } fault_cause_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } access_e;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [FLAG_W-1:0]  flags;
    } pte_t;

    typedef struct packed {
        logic [IDX_W-1:0] hi;
        logic [IDX_W-1:0] lo;
        logic [OFF_W-1:0] off;
    } vaddr_t;

    // Byte address of entry idx in the table held in frame base
    function automatic logic [VA_W-1:0] entry_addr(
        input logic [FRAME_W-1:0] base,
        input logic [IDX_W-1:0]   idx
    );
        logic [VA_W-1:0] scaled;
        scaled = VA_W'(idx) << ENTRY_SH;
        return {base, {OFF_W{1'b0}}} + scaled;
    endfunction

    function automatic logic flag_valid(input logic [FLAG_W-1:0] flags);
        return flags[FLG_VALID];
    endfunction

    // Permission lookup for the access kind
    function automatic logic perm_ok(
        input logic [FLAG_W-1:0] flags,
        input access_e           acc
    );
        logic ok;
        case (acc)
            ACC_READ:  ok = flags[FLG_READ];
            ACC_WRITE: ok = flags[FLG_WRITE];
            ACC_EXEC:  ok = flags[FLG_EXEC];
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  walk_state_e            state,
    input  logic [FRAME_W-1:0]     root_frame,
    input  logic [FRAME_W-1:0]     inner_frame,
    input  logic [IDX_W-1:0]       idx_hi,
    input  logic [IDX_W-1:0]       idx_lo,
    output logic                   mem_req,
    output logic [VA_W-1:0]        mem_addr
);
    localparam int LEVELS = 2;

    logic [FRAME_W-1:0] lvl_base [LEVELS];
    logic [IDX_W-1:0]   lvl_idx  [LEVELS];
    logic [VA_W-1:0]    lvl_addr [LEVELS];

    assign lvl_base[0] = root_frame;
    assign lvl_idx[0]  = idx_hi;
    assign lvl_base[1] = inner_frame;
    assign lvl_idx[1]  = idx_lo;

    for (genvar g = 0; g < LEVELS; g++) begin : g_level
        assign lvl_addr[g] = entry_addr(lvl_base[g], lvl_idx[g]);
    end

    always_comb begin
        mem_req  = 1'b0;
        mem_addr = '0;
        case (state)
            ST_RD_OUTER: begin
                mem_req  = 1'b1;
                mem_addr = lvl_addr[0];
            end
            ST_RD_INNER: begin
                mem_req  = 1'b1;
                mem_addr = lvl_addr[1];
            end
            default: begin
                mem_req  = 1'b0;
                mem_addr = '0;
            end
        endcase
    end

endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
    import ptw_pkg::*;
(
    input  pte_t          pte,
    input  logic          level_inner,
    input  access_e       acc,
    output logic          ok,
    output fault_cause_e  cause
);
    logic valid_bit;
    logic perm_bit;

    assign valid_bit = flag_valid(pte.flags);
    assign perm_bit  = perm_ok(pte.flags, acc);

    // Validity first; permission only on the last level
    always_comb begin
        if (!valid_bit) begin
            cause = level_inner ? CAUSE_INNER_INV : CAUSE_OUTER_INV;
        end else if (level_inner && !perm_bit) begin
            cause = CAUSE_PROT;
        end else begin
            cause = CAUSE_NONE;
        end
        ok = (cause == CAUSE_NONE);
    end

endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  vaddr_t               req_vaddr,
    input  access_e              req_access,
    input  logic [FRAME_W-1:0]   ptbr,
    input  logic                 mem_rvalid,
    input  logic [FRAME_W-1:0]   rd_frame,
    input  logic                 chk_ok,
    input  fault_cause_e         chk_cause,
    output walk_state_e          state,
    output logic [FRAME_W-1:0]   root_q,
    output logic [FRAME_W-1:0]   inner_q,
    output logic [IDX_W-1:0]     idx_hi_q,
    output logic [IDX_W-1:0]     idx_lo_q,
    output access_e              acc_q,
    output logic                 ready,
    output logic                 resp_valid,
    output logic                 resp_fault,
    output fault_cause_e         resp_cause,
    output logic [VA_W-1:0]      resp_paddr
);
    vaddr_t          va_q;
    fault_cause_e    cause_q;
    logic [VA_W-1:0] paddr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            va_q    <= '0;
            acc_q   <= ACC_READ;
            root_q  <= '0;
            inner_q <= '0;
            cause_q <= CAUSE_NONE;
            paddr_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q   <= req_vaddr;
                        acc_q  <= req_access;
                        root_q <= ptbr;
                        state  <= ST_RD_OUTER;
                    end
                end
                ST_RD_OUTER: begin
                    if (mem_rvalid) begin
                        if (chk_ok) begin
                            inner_q <= rd_frame;
                            state   <= ST_RD_INNER;
                        end else begin
                            cause_q <= chk_cause;
                            paddr_q <= '0;
                            state   <= ST_FAULT;
                        end
                    end
                end
                ST_RD_INNER: begin
                    if (mem_rvalid) begin
                        if (chk_ok) begin
                            cause_q <= CAUSE_NONE;
                            paddr_q <= {rd_frame, va_q.off};
                            state   <= ST_DONE;
                        end else begin
                            cause_q <= chk_cause;
                            paddr_q <= '0;
                            state   <= ST_FAULT;
                        end
                    end
                end
                ST_DONE:  state <= ST_IDLE;
                ST_FAULT: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    assign idx_hi_q   = va_q.hi;
    assign idx_lo_q   = va_q.lo;
    assign ready      = (state == ST_IDLE);
    assign resp_valid = (state == ST_DONE) || (state == ST_FAULT);
    assign resp_fault = (state == ST_FAULT);
    assign resp_cause = cause_q;
    assign resp_paddr = paddr_q;

endmodule

// File: rtl/ptw_top.sv
module ptw_top
    import ptw_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [VA_W-1:0]     req_vaddr,
    input  logic [1:0]          req_access,
    input  logic [FRAME_W-1:0]  ptbr,
    output logic                ready,
    output logic                mem_req,
    output logic [VA_W-1:0]     mem_addr,
    input  logic                mem_rvalid,
    input  logic [PTE_W-1:0]    mem_rdata,
    output logic                resp_valid,
    output logic                resp_fault,
    output logic [1:0]          resp_cause,
    output logic [VA_W-1:0]     resp_paddr
);
    walk_state_e        state;
    logic [FRAME_W-1:0] root_q;
    logic [FRAME_W-1:0] inner_q;
    logic [IDX_W-1:0]   idx_hi_q;
    logic [IDX_W-1:0]   idx_lo_q;
    access_e            acc_q;
    logic               chk_ok;
    fault_cause_e       chk_cause;
    fault_cause_e       cause_e;
    pte_t               rd_pte;

    assign rd_pte = pte_t'(mem_rdata);

    ptw_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_vaddr  (vaddr_t'(req_vaddr)),
        .req_access (access_e'(req_access)),
        .ptbr       (ptbr),
        .mem_rvalid (mem_rvalid),
        .rd_frame   (rd_pte.frame),
        .chk_ok     (chk_ok),
        .chk_cause  (chk_cause),
        .state      (state),
        .root_q     (root_q),
        .inner_q    (inner_q),
        .idx_hi_q   (idx_hi_q),
        .idx_lo_q   (idx_lo_q),
        .acc_q      (acc_q),
        .ready      (ready),
        .resp_valid (resp_valid),
        .resp_fault (resp_fault),
        .resp_cause (cause_e),
        .resp_paddr (resp_paddr)
    );

    ptw_addr_gen u_addr (
        .state       (state),
        .root_frame  (root_q),
        .inner_frame (inner_q),
        .idx_hi      (idx_hi_q),
        .idx_lo      (idx_lo_q),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr)
    );

    ptw_pte_check u_chk_pte (
        .pte         (rd_pte),
        .level_inner (state == ST_RD_INNER),
        .acc         (acc_q),
        .ok          (chk_ok),
        .cause       (chk_cause)
    );

    assign resp_cause = cause_e;

endmodule

// File: rtl/ptw_checker.sv
module ptw_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [31:0] req_vaddr,
    input logic        ready,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_rvalid,
    input logic        resp_valid,
    input logic        resp_fault,
    input logic [1:0]  resp_cause,
    input logic [31:0] resp_paddr
);
    logic [11:0] off_q;

    always_ff @(posedge clk) begin
        if (rst) off_q <= '0;
        else if (req_valid && ready) off_q <= req_vaddr[11:0];
    end

    // R1: idle walker issues nothing and reports nothing
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        ready |-> (!mem_req && !resp_valid));

    // R2: an accepted request starts a read in the next cycle
    p_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && ready) |=> (!ready && mem_req));

    // R3: read held with a stable address until data returns
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    // R3: entry addresses are word aligned
    p_aligned_r3: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R6: success keeps the offset and carries no cause
    p_offset_kept_r6: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_fault) |-> (resp_paddr[11:0] == off_q && resp_cause == 2'd0));

    // R7: a fault always carries a nonzero cause
    p_fault_cause_r7: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_fault) |-> (resp_cause != 2'd0));

    // R10: result strobe lasts one cycle, then the walker is idle
    p_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> (!resp_valid && ready));

endmodule

bind ptw_top ptw_checker u_ptw_checker (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_vaddr  (req_vaddr),
    .ready      (ready),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .resp_valid (resp_valid),
    .resp_fault (resp_fault),
    .resp_cause (resp_cause),
    .resp_paddr (resp_paddr)
);

// File: tb/tb_ptw_top.sv
module tb_ptw_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_access = '0;
    logic [19:0] ptbr = 20'h00010;
    logic        ready;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        resp_valid;
    logic        resp_fault;
    logic [1:0]  resp_cause;
    logic [31:0] resp_paddr;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int lat = 1;
    int rv_cyc = 0;
    logic [31:0] mem [int unsigned];
    logic [31:0] addr_log [$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ptw_top dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_access(req_access), .ptbr(ptbr), .ready(ready), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_cause(resp_cause),
        .resp_paddr(resp_paddr)
    );

    function automatic logic [31:0] rd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    task automatic check(input bit cond, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Memory model: answers each held read after lat cycles
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req && !rst) begin
                logic [31:0] a;
                a = mem_addr;
                addr_log.push_back(a);
                repeat (lat - 1) @(negedge clk);
                mem_rdata  = rd(a);
                mem_rvalid = 1'b1;
                rv_cyc     = cyc;
                @(negedge clk);
                mem_rvalid = 1'b0;
                mem_rdata  = 32'h0;
            end
        end
    end

    // Behavioural walk over the bench memory
    task automatic ref_walk(input logic [31:0] va, input logic [1:0] acc, input logic [19:0] root,
                            output bit flt, output logic [1:0] cause, output logic [31:0] pa,
                            output int n, output logic [31:0] a0, output logic [31:0] a1);
        logic [31:0] e0, e1;
        bit ok;
        a0 = {root, 12'h000} + {20'h0, va[31:22], 2'b00};
        a1 = 32'h0; pa = 32'h0;
        e0 = rd(a0);
        if (!e0[0]) begin
            flt = 1; cause = 2'd1; n = 1;
            return;
        end
        a1 = {e0[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
        n = 2;
        e1 = rd(a1);
        if (!e1[0]) begin
            flt = 1; cause = 2'd2;
            return;
        end
        ok = (acc == 2'd0 && e1[1]) || (acc == 2'd1 && e1[2]) || (acc == 2'd2 && e1[3]);
        if (!ok) begin
            flt = 1; cause = 2'd3;
            return;
        end
        flt = 0; cause = 2'd0; pa = {e1[31:12], va[11:0]};
    endtask

    task automatic walk(input logic [31:0] va, input logic [1:0] acc, input int l,
                        input bit poke, input string req);
        bit flt; logic [1:0] cause; logic [31:0] pa, a0, a1; int n; int k;
        ref_walk(va, acc, ptbr, flt, cause, pa, n, a0, a1);
        lat = l;
        addr_log.delete();
        @(negedge clk);
        check(ready == 1'b1, "R2", "ready before request", {31'h0, ready}, 32'h1);
        req_valid = 1'b1; req_vaddr = va; req_access = acc;
        @(negedge clk);
        req_valid = 1'b0;
        k = 0;
        while (!resp_valid && k < 400) begin
            if (poke && k == 1) begin
                req_valid = 1'b1; req_vaddr = 32'h0; req_access = 2'd3;
            end else begin
                req_valid = 1'b0; req_vaddr = va; req_access = acc;
            end
            @(negedge clk);
            k++;
        end
        req_valid = 1'b0;
        check(resp_valid == 1'b1, req, "result arrives", {31'h0, resp_valid}, 32'h1);
        check(cyc == rv_cyc + 1, "R10", "result one cycle after last data", cyc, rv_cyc + 1);
        check(resp_fault == flt, req, "fault flag", {31'h0, resp_fault}, {31'h0, flt});
        check(resp_cause == cause, req, "cause", {30'h0, resp_cause}, {30'h0, cause});
        if (!flt) check(resp_paddr == pa, "R6", "physical address", resp_paddr, pa);
        check(addr_log.size() == n, (n == 1) ? "R7" : "R4", "read count", addr_log.size(), n);
        if (addr_log.size() >= 1) check(addr_log[0] == a0, "R3", "outer entry address", addr_log[0], a0);
        if (n == 2 && addr_log.size() >= 2) check(addr_log[1] == a1, "R4", "inner entry address", addr_log[1], a1);
        @(negedge clk);
        check(!resp_valid && ready, "R10", "strobe single and ready back",
              {30'h0, resp_valid, ready}, 32'h1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // Tables (R5 entry layout: frame in 31:12, flags V=bit0 R=1 W=2 X=3)
        mem[32'h0001_0004] = {20'h00020, 12'h001};
        mem[32'h0002_000C] = {20'hABCDE, 12'h00F};
        mem[32'h0002_0018] = {20'h11111, 12'h00E};
        mem[32'h0002_001C] = {20'h55555, 12'h005};
        mem[32'h0002_0020] = {20'h66666, 12'h009};
        mem[32'h0002_0024] = {20'h00000, 12'h003};
        mem[32'h0001_0FFC] = {20'h00030, 12'h000 | 12'h001};
        mem[32'h0003_0FFC] = {20'h12345, 12'h003};
        mem[32'h0004_0008] = {20'h00020, 12'h000 | 12'h001};

        repeat (3) @(negedge clk);
        check(ready && !mem_req && !resp_valid, "R1", "state during reset",
              {29'h0, ready, mem_req, resp_valid}, 32'h4);
        rst = 1'b0;
        @(negedge clk);
        check(ready && !mem_req && !resp_valid, "R1", "state after reset",
              {29'h0, ready, mem_req, resp_valid}, 32'h4);

        walk(32'h0040_3ABC, 2'd0, 1, 0, "R6");   // read, full RWX page
        walk(32'h0040_3ABC, 2'd2, 3, 0, "R11");  // exec, slower memory
        walk(32'hFFFF_F123, 2'd0, 7, 0, "R6");   // top indexes, read ok
        walk(32'hFFFF_F123, 2'd1, 2, 0, "R9");   // write on read-only page
        walk(32'hFFFF_F123, 2'd2, 1, 0, "R9");   // exec on read-only page
        walk(32'h0000_0456, 2'd0, 2, 0, "R7");   // outer entry missing
        walk(32'h0040_5000, 2'd0, 1, 0, "R8");   // inner entry missing
        walk(32'h0040_6010, 2'd0, 3, 0, "R8");   // invalid with RWX set
        walk(32'h0040_3ABC, 2'd3, 1, 0, "R9");   // reserved access code
        walk(32'h0040_7FFF, 2'd1, 1, 0, "R9");   // write-only page write
        walk(32'h0040_7FFF, 2'd0, 1, 0, "R9");   // write-only page read
        walk(32'h0040_8001, 2'd2, 2, 0, "R9");   // exec-only page
        walk(32'h0040_9FED, 2'd0, 1, 0, "R6");   // frame zero
        walk(32'h0040_3ABC, 2'd0, 4, 1, "R2");   // request while busy ignored
        ptbr = 20'h00040;
        walk(32'h0080_3ABC, 2'd0, 1, 0, "R3");   // new root table
        walk(32'h0040_3ABC, 2'd0, 1, 0, "R7");   // idx 1 empty under new root

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule